// File: doc/BRIEF.md
# Character Glyph Fetch and Attribute Alignment Pipeline

This block sits between a display timing controller, a row buffer and a character-generator memory. Each time the character-clock enable pulses, the block registers the current character code, the attribute byte and the blank level. It also advances a 4-bit scan-line register that is loaded serially from the controller.

The block joins the registered character code and scan-line row into a glyph-memory address. One cycle later it reads the glyph byte for the dot serializer. Blink, background and blank each pass through a short shift delay, so they reach the outputs in step with the fetched glyph. Character enable, the two mode-select bits and the cell width are only registered.

A host can read and write the glyph memory one byte at a time. The display fetch always has priority: a host request made in a fetch cycle waits one cycle before it is served.

Top module: `cgp_top`

## Requirements
- R1: Reset is asynchronous and active low, and its release takes effect after two clock edges. While the block is in reset, every output is 0: the delayed attributes, char_en, mode_sel, dot_count, cg_addr, glyph_out, host_rdata and host_ack.
- R2: Attribute bit 0 is blink and bit 1 is background. A value sampled on the tick at clock k appears on blink_out or bkgnd_out right after tick k+2, with DLY_STAGES=3. Between ticks these outputs do not change.
- R3: blank_in passes through the same delay as R2 and drives retrace_blank.
- R4: On a tick with sl_gate low, the scan-line register shifts right and sl_data enters at bit 3. On a tick with sl_gate high, the register holds its value.
- R5: cg_addr equals the character code registered on the last tick, shifted left by ROW_W, ORed with the scan-line register.
- R6: In the cycle after each tick, glyph_out loads the memory byte at cg_addr. At all other times glyph_out holds its value.
- R7: A host request in a cycle that follows a tick is not served in that cycle. host_ack stays 0 on the next edge.
- R8: The block serves a pending host request on the first cycle that is not a fetch cycle. host_ack pulses for exactly one cycle on the next edge. A write (host_we=1) stores host_wdata at host_addr. A read returns the byte at host_addr on host_rdata together with the ack.
- R9: Attribute bit 2 is character enable, and bits 4:3 are mode_sel[1:0]. Both are registered on a tick with no extra delay.
- R10: dot_count is registered on a tick. It is 10 when wide_cell is 1 and 8 when wide_cell is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_tick | input | 1 | Character-clock enable |
| attr_in | input | 8 | Attribute byte |
| code_in | input | CODE_W | Character code |
| blank_in | input | 1 | Composite blank |
| sl_data | input | 1 | Serial scan-line bit |
| sl_gate | input | 1 | Scan-line hold (high holds) |
| wide_cell | input | 1 | Selects 10-dot cells |
| host_req | input | 1 | Host access request, held until ack |
| host_we | input | 1 | Host write select |
| host_addr | input | CODE_W+ROW_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| blink_out | output | 1 | Delayed blink |
| bkgnd_out | output | 1 | Delayed background |
| retrace_blank | output | 1 | Delayed blank |
| char_en | output | 1 | Character enable |
| mode_sel | output | 2 | Mode-select bits |
| dot_count | output | 4 | Dots per cell |
| cg_addr | output | CODE_W+ROW_W | Glyph-memory address |
| glyph_out | output | DATA_W | Fetched glyph byte |
| host_rdata | output | DATA_W | Host read data |
| host_ack | output | 1 | Host access done |

## Verification
The bench uses the default parameters: an 8-bit code, a 4-bit row, an 8-bit glyph and three delay stages. With these values the glyph memory covers the full 4096-byte space. The bench can serially load all sixteen rows and can reach the lowest and highest character codes, 0x00 and 0xFF. The two-tick attribute alignment is checked directly after reset, starting from cleared delay stages. The test also collides a host request with a fetch cycle to confirm that the fetch wins.

// File: rtl/cgp_pkg.sv
package cgp_pkg;
  localparam int ATTR_W      = 8;
  localparam int A_BLINK     = 0;
  localparam int A_BKGND     = 1;
  localparam int A_CHEN      = 2;
  localparam int A_MODE_LO   = 3;
  localparam int N_DELAYED   = 3;
  localparam int DOTS_W      = 4;

  typedef enum logic [1:0] {
    DL_BLINK = 2'd0,
    DL_BKGND = 2'd1,
    DL_BLANK = 2'd2
  } delay_lane_e;

  function automatic logic [DOTS_W-1:0] cell_dots(input logic wide);
    cell_dots = wide ? DOTS_W'(10) : DOTS_W'(8);
  endfunction
endpackage

// File: rtl/cgp_shift_delay.sv
module cgp_shift_delay #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (adv) sh_d = {din, sh_q[STAGES-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[0];

  // R2 / R3: output moves only on a character tick
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(dout));
  // R3: newest sample lands in the top stage
  p_enter_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> sh_q[STAGES-1] == $past(din));
endmodule

// File: rtl/cgp_scanline_shift.sv
module cgp_scanline_shift #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             gate,
  input  logic             sdata,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;
  logic             shift_en;

  assign shift_en = adv && !gate;

  always_comb begin
    row_d = row_q;
    if (shift_en) row_d = {sdata, row_q[ROW_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv || gate) |=> $stable(row));
  p_serial_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !gate) |=> row[ROW_W-1] == $past(sdata));
endmodule

// File: rtl/cgp_glyph_store.sv
module cgp_glyph_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] glyph,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] glyph_q, glyph_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ack_q, ack_d;
  logic              host_go;

  assign host_go = host_req && !fetch && !ack_q;

  always_comb begin
    glyph_d = glyph_q;
    rdata_d = rdata_q;
    ack_d   = host_go;
    if (fetch) glyph_d = mem[fetch_addr];
    if (host_go && !host_we) rdata_d = mem[host_addr];
  end

  always_ff @(posedge clk) begin
    if (host_go && host_we) mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glyph_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      glyph_q <= glyph_d;
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
    end
  end

  assign glyph      = glyph_q;
  assign host_rdata = rdata_q;
  assign host_ack   = ack_q;

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  p_fetch_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && host_req) |=> !host_ack);
  p_glyph_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(glyph));
endmodule

// File: rtl/cgp_top.sv
module cgp_top #(
  parameter int CODE_W     = 8,
  parameter int ROW_W      = 4,
  parameter int DATA_W     = 8,
  parameter int DLY_STAGES = 3,
  localparam int ADDR_W    = CODE_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_tick,
  input  logic [7:0]        attr_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              blank_in,
  input  logic              sl_data,
  input  logic              sl_gate,
  input  logic              wide_cell,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              blink_out,
  output logic              bkgnd_out,
  output logic              retrace_blank,
  output logic              char_en,
  output logic [1:0]        mode_sel,
  output logic [3:0]        dot_count,
  output logic [ADDR_W-1:0] cg_addr,
  output logic [DATA_W-1:0] glyph_out,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack
);
  import cgp_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [CODE_W-1:0] code_q, code_d;
  logic              chen_q, chen_d;
  logic [1:0]        mode_q, mode_d;
  logic [DOTS_W-1:0] dots_q, dots_d;
  logic              fetch_q;

  always_comb begin
    code_d = code_q;
    chen_d = chen_q;
    mode_d = mode_q;
    dots_d = dots_q;
    if (char_tick) begin
      code_d = code_in;
      chen_d = attr_in[A_CHEN];
      mode_d = attr_in[A_MODE_LO +: 2];
      dots_d = cell_dots(wide_cell);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_q  <= '0;
      chen_q  <= 1'b0;
      mode_q  <= 2'b00;
      dots_q  <= '0;
      fetch_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      chen_q  <= chen_d;
      mode_q  <= mode_d;
      dots_q  <= dots_d;
      fetch_q <= char_tick;
    end
  end

  logic [N_DELAYED-1:0] lane_in;
  logic [N_DELAYED-1:0] lane_out;

  assign lane_in[DL_BLINK] = attr_in[A_BLINK];
  assign lane_in[DL_BKGND] = attr_in[A_BKGND];
  assign lane_in[DL_BLANK] = blank_in;

  for (genvar g = 0; g < N_DELAYED; g++) begin : g_lane
    cgp_shift_delay #(.STAGES(DLY_STAGES)) u_dly (
      .clk  (clk),
      .rst_n(rst_int_n),
      .adv  (char_tick),
      .din  (lane_in[g]),
      .dout (lane_out[g])
    );
  end

  logic [ROW_W-1:0] row;

  cgp_scanline_shift #(.ROW_W(ROW_W)) u_row (
    .clk  (clk),
    .rst_n(rst_int_n),
    .adv  (char_tick),
    .gate (sl_gate),
    .sdata(sl_data),
    .row  (row)
  );

  assign cg_addr = {code_q, row};

  cgp_glyph_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fetch     (fetch_q),
    .fetch_addr(cg_addr),
    .host_req  (host_req),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .glyph     (glyph_out),
    .host_rdata(host_rdata),
    .host_ack  (host_ack)
  );

  assign blink_out     = lane_out[DL_BLINK];
  assign bkgnd_out     = lane_out[DL_BKGND];
  assign retrace_blank = lane_out[DL_BLANK];
  assign char_en       = chen_q;
  assign mode_sel      = mode_q;
  assign dot_count     = dots_q;

  p_chen_tick_only_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !char_tick |=> $stable(char_en) && $stable(mode_sel));
  p_dots_legal_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    char_tick |=> (dot_count == 4'd8 || dot_count == 4'd10));
endmodule

// File: tb/sim_cgp_top.sv
module sim_cgp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_tick = 1'b0;
  logic [7:0]  attr_in = '0;
  logic [7:0]  code_in = '0;
  logic        blank_in = 1'b0;
  logic        sl_data = 1'b0;
  logic        sl_gate = 1'b1;
  logic        wide_cell = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        blink_out, bkgnd_out, retrace_blank, char_en, host_ack;
  logic [1:0]  mode_sel;
  logic [3:0]  dot_count;
  logic [11:0] cg_addr;
  logic [7:0]  glyph_out, host_rdata;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cgp_top u0 (
    .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .attr_in(attr_in),
    .code_in(code_in), .blank_in(blank_in), .sl_data(sl_data), .sl_gate(sl_gate),
    .wide_cell(wide_cell), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .blink_out(blink_out),
    .bkgnd_out(bkgnd_out), .retrace_blank(retrace_blank), .char_en(char_en),
    .mode_sel(mode_sel), .dot_count(dot_count), .cg_addr(cg_addr),
    .glyph_out(glyph_out), .host_rdata(host_rdata), .host_ack(host_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] c, input logic [3:0] r);
    pat = (c * 8'd7) ^ ({4'd0, r} * 8'd37) ^ 8'h5A;
  endfunction

  task automatic do_tick(input logic [7:0] a, input logic [7:0] c, input logic bl,
                         input logic sd, input logic gt, input logic wd);
    @(negedge clk);
    attr_in = a; code_in = c; blank_in = bl; sl_data = sd; sl_gate = gt;
    wide_cell = wd; char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic host_op(input logic we, input logic [11:0] ad, input logic [7:0] wd,
                         output logic [7:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = ad; host_wdata = wd;
    do @(negedge clk); while (!host_ack);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 blink", blink_out, 0);
    chk("R1 blank", retrace_blank, 0);
    chk("R1 addr", cg_addr, 0);
    chk("R1 glyph", glyph_out, 0);
    chk("R1 ack", host_ack, 0);
    chk("R1 mode/en/dots", {mode_sel, char_en, dot_count}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_attr_delay;
    logic [7:0] av [8];
    logic       bv [8];
    logic       hb, hk, hl;
    for (int i = 0; i < 8; i++) begin
      av[i] = 8'(i * 3 + 1);
      bv[i] = (i % 3) == 1;
    end
    for (int k = 0; k < 8; k++) begin
      do_tick(av[k], 8'h00, bv[k], 1'b0, 1'b1, 1'b0);
      chk("R2 blink", blink_out, (k >= 2) ? av[k-2][0] : 1'b0);
      chk("R2 bkgnd", bkgnd_out, (k >= 2) ? av[k-2][1] : 1'b0);
      chk("R3 blank", retrace_blank, (k >= 2) ? bv[k-2] : 1'b0);
    end
    hb = blink_out; hk = bkgnd_out; hl = retrace_blank;
    attr_in = 8'hFF; blank_in = ~blank_in;
    repeat (4) @(negedge clk);
    chk("R2 hold between ticks", {blink_out, bkgnd_out}, {hb, hk});
    chk("R3 hold between ticks", retrace_blank, hl);
  endtask

  task automatic t_load_table;
    logic [7:0] codes [3];
    logic [7:0] rd;
    codes[0] = 8'h00; codes[1] = 8'h41; codes[2] = 8'hFF;
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 16; r++)
        host_op(1'b1, {codes[c], 4'(r)}, pat(codes[c], 4'(r)), rd);
    host_op(1'b0, {8'h41, 4'd9}, 8'h00, rd);
    chk("R8 read back", rd, pat(8'h41, 4'd9));
    host_op(1'b0, {8'hFF, 4'd15}, 8'h00, rd);
    chk("R8 read back top", rd, pat(8'hFF, 4'd15));
  endtask

  task automatic t_rows;
    logic [7:0] codes [3];
    logic [3:0] rows [4];
    codes[0] = 8'h00; codes[1] = 8'h41; codes[2] = 8'hFF;
    rows[0] = 4'd0; rows[1] = 4'd9; rows[2] = 4'd6; rows[3] = 4'd15;
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < 4; b++)
          do_tick(8'h00, codes[c], 1'b0, rows[r][b], 1'b0, 1'b0);
        do_tick(8'h00, codes[c], 1'b0, ~rows[r][0], 1'b1, 1'b0);
        chk("R4/R5 address", cg_addr, {codes[c], rows[r]});
        @(negedge clk);
        chk("R6 glyph", glyph_out, pat(codes[c], rows[r]));
      end
    do_tick(8'h00, 8'h41, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 shift one", cg_addr[3:0], 4'b1111);
  endtask

  task automatic t_arbitration;
    logic [7:0] g;
    g = glyph_out;
    @(negedge clk);
    code_in = 8'h41; sl_gate = 1'b1; char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
    host_req = 1'b1; host_we = 1'b0; host_addr = {8'h00, 4'd6};
    @(negedge clk);
    chk("R7 deferred in fetch cycle", host_ack, 0);
    @(negedge clk);
    chk("R8 ack after fetch", host_ack, 1);
    chk("R8 read data", host_rdata, pat(8'h00, 4'd6));
    host_req = 1'b0;
    @(negedge clk);
    chk("R8 single pulse", host_ack, 0);
    chk("R6 glyph from fetch", glyph_out, pat(8'h41, 4'd15));
    if (g === 8'hxx) chk("R6 prior glyph", 0, 1);
  endtask

  task automatic t_passthru;
    do_tick(8'b0001_1100, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 char_en", char_en, 1);
    chk("R9 mode_sel", mode_sel, 2'b11);
    chk("R10 wide", dot_count, 10);
    do_tick(8'b0000_1000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 char_en low", char_en, 0);
    chk("R9 mode_sel 01", mode_sel, 2'b01);
    chk("R10 narrow", dot_count, 8);
    attr_in = 8'h1C;
    repeat (3) @(negedge clk);
    chk("R9 hold without tick", {char_en, mode_sel}, 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_attr_delay();
    t_load_table();
    t_rows();
    t_arbitration();
    t_passthru();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule